// File: doc/BRIEF.md
# Systolic 1D Convolution Array

This block computes a one-dimensional convolution over a stream of 16-bit signed fixed-point samples. It is built as a linear chain of `K` processing elements. Each element holds one kernel coefficient for a whole run. Samples enter the first element and move down the chain. Partial sums travel alongside them, and each element adds its own rounded product. Every finished sum leaves the last element, is clamped to the 16-bit range, and is returned as a signed integer field and an unsigned fraction field. All words use a 16-bit signed format with a sign bit, 6 integer bits and 9 fraction bits. That format covers -64 to 63.998046875 in steps of 1/512.

A run begins when `en` is raised while the block is idle. The block first reads the `K` coefficients from an external weight memory. It then reads samples from an external sample memory, one address per clock, for as long as `en` stays high. Both memories are expected to return data one clock after the address. When `en` falls, the array drains the results that are still in flight and then returns to idle.

Top module: `conv1d_sys_array`

## Requirements
- R1: Each result word is a 16-bit two's-complement value with 9 fraction bits. `res_int` carries bits 15..9 of that word, which is the signed integer part including the sign. `res_frac` carries bits 8..0.
- R2: When `en` is high in idle, `wt_rd` is asserted for exactly `K` consecutive cycles with `wt_addr` = 0, 1, …, K-1. The word returned for address i becomes coefficient w[i] for the run.
- R3: In the cycle after the last coefficient address, sample fetching starts. `smp_rd` is high with `smp_addr` = 0, 1, 2, … on consecutive cycles while `en` stays high. It drops in the same cycle that `en` is low.
- R4: The result for sample index n is y[n] = sat(Σ_{i=0..K-1} r(w[i]·x[n-i])). Here r(p) = floor((p + 256) / 512) applied to the 32-bit product, so halves round upward.
- R5: If the exact sum exceeds 32767 the word is 0x7FFF. If it is below -32768 the word is 0x8000.
- R6: One valid result is produced per fetched sample with index n ≥ K-1, in sample order. It appears with `res_valid` high on the (K+1)th rising edge after the edge that sampled address n.
- R7: No result is flagged for the first K-1 samples of a run.
- R8: While a run is draining, `en` is ignored. No coefficient or sample fetch starts until every in-flight result of the run has been delivered.
- R9: Driving `rst_n` low clears `res_valid`, `wt_rd`, `smp_rd`, `res_int` and `res_frac` at once, without waiting for a clock edge. Release takes effect through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Starts a run from idle; keeps sample fetching going while high |
| wt_rd | output | 1 | Coefficient read strobe |
| wt_addr | output | 2 | Coefficient address (log2 K) |
| wt_data | input | 16 | Coefficient word, valid one cycle after the address |
| smp_rd | output | 1 | Sample read strobe |
| smp_addr | output | 8 | Sample address (AW) |
| smp_data | input | 16 | Sample word, valid one cycle after the address |
| res_valid | output | 1 | Result fields hold a finished output |
| res_int | output | 7 | Signed integer part of the result |
| res_frac | output | 9 | Fraction part of the result |

## Verification
Two events meet in the same cycle. The last coefficient is written into the final element in the very cycle that the first sample address goes out. Every run exercises this pairing, and a wrong value in w[K-1] shows up in the very first output compared against the bench's model. Draining a finished run can also coincide with `en` being raised again. The bench raises `en` during the drain and judges the result by two things: the fetch strobes must stay low, and every remaining result of the old run must arrive with the expected value and cycle.

// File: rtl/conv1d_pkg.sv
package conv1d_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOAD   = 2'd1,
    ST_STREAM = 2'd2,
    ST_DRAIN  = 2'd3
  } conv_state_e;

endpackage

// File: rtl/conv1d_ctrl.sv
module conv1d_ctrl
  import conv1d_pkg::*;
#(
  parameter int K   = 4,
  parameter int AW  = 8,
  parameter int KAW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  output logic           wt_rd,
  output logic [KAW-1:0] wt_addr,
  output logic           smp_rd,
  output logic [AW-1:0]  smp_addr,
  output logic           ld_en_q,
  output logic [KAW-1:0] ld_idx_q,
  output logic           tag_q
);

  localparam int DRAIN_LEN = K + 2;
  localparam int DCW       = $clog2(DRAIN_LEN + 1);
  localparam logic [KAW-1:0] LAST_IDX = KAW'(K - 1);

  conv_state_e    state_q, state_d;
  logic [KAW-1:0] ld_cnt_q, ld_cnt_d;
  logic [AW-1:0]  addr_q, addr_d;
  logic [KAW-1:0] fill_q, fill_d;
  logic [DCW-1:0] drain_q, drain_d;
  logic           tag_d;

  always_comb begin
    state_d  = state_q;
    ld_cnt_d = ld_cnt_q;
    addr_d   = addr_q;
    fill_d   = fill_q;
    drain_d  = drain_q;
    case (state_q)
      ST_IDLE: begin
        if (en) begin
          state_d  = ST_LOAD;
          ld_cnt_d = '0;
        end
      end
      ST_LOAD: begin
        if (ld_cnt_q == LAST_IDX) begin
          state_d = ST_STREAM;
          addr_d  = '0;
          fill_d  = '0;
        end else begin
          ld_cnt_d = ld_cnt_q + 1'b1;
        end
      end
      ST_STREAM: begin
        if (en) begin
          addr_d = addr_q + 1'b1;
          if (fill_q != LAST_IDX) fill_d = fill_q + 1'b1;
        end else begin
          state_d = ST_DRAIN;
          drain_d = '0;
        end
      end
      default: begin
        if (drain_q == DCW'(DRAIN_LEN - 1)) state_d = ST_IDLE;
        else                                drain_d = drain_q + 1'b1;
      end
    endcase
  end

  assign wt_rd    = (state_q == ST_LOAD);
  assign wt_addr  = ld_cnt_q;
  assign smp_rd   = (state_q == ST_STREAM) && en;
  assign smp_addr = addr_q;
  assign tag_d    = smp_rd && (fill_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      ld_cnt_q <= '0;
      addr_q   <= '0;
      fill_q   <= '0;
      drain_q  <= '0;
      ld_en_q  <= 1'b0;
      ld_idx_q <= '0;
      tag_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      ld_cnt_q <= ld_cnt_d;
      addr_q   <= addr_d;
      fill_q   <= fill_d;
      drain_q  <= drain_d;
      ld_en_q  <= wt_rd;
      ld_idx_q <= wt_addr;
      tag_q    <= tag_d;
    end
  end

  // R2: coefficient fetch starts at address zero and steps by one
  p_wt_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wt_rd) |-> (wt_addr == '0));
  p_wt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wt_rd && $past(wt_rd)) |-> (wt_addr == KAW'($past(wt_addr) + 1'b1)));

  // R3: sample fetch starts at address zero and steps by one
  p_smp_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smp_rd) |-> (smp_addr == '0));
  p_smp_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_rd && $past(smp_rd)) |-> (smp_addr == AW'($past(smp_addr) + 1'b1)));

  // R8: a coefficient fetch never follows a sample fetch directly
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    smp_rd |=> !wt_rd);

endmodule

// File: rtl/conv1d_pe.sv
module conv1d_pe #(
  parameter int W     = 16,
  parameter int FRAC  = 9,
  parameter int ACC_W = 26
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    w_ld,
  input  logic signed [W-1:0]     w_data,
  input  logic signed [W-1:0]     x_in,
  input  logic signed [ACC_W-1:0] psum_in,
  output logic signed [W-1:0]     x_out,
  output logic signed [ACC_W-1:0] psum_out
);

  localparam int PW = 2 * W;
  localparam logic signed [PW-1:0] RND_BIAS =
    {{(PW - FRAC){1'b0}}, 1'b1, {(FRAC - 1){1'b0}}};

  logic signed [W-1:0]     w_q, w_d;
  logic signed [W-1:0]     x_a_q, x_b_q;
  logic signed [ACC_W-1:0] psum_q, psum_d;
  logic signed [PW-1:0]    prod, prod_rnd;

  always_comb begin
    w_d      = w_ld ? w_data : w_q;
    prod     = x_in * w_q;
    prod_rnd = prod + RND_BIAS;
    psum_d   = psum_in + ACC_W'(prod_rnd >>> FRAC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q    <= '0;
      x_a_q  <= '0;
      x_b_q  <= '0;
      psum_q <= '0;
    end else begin
      w_q    <= w_d;
      x_a_q  <= x_in;
      x_b_q  <= x_a_q;
      psum_q <= psum_d;
    end
  end

  assign x_out    = x_b_q;
  assign psum_out = psum_q;

  // R2: the held coefficient changes only through a load strobe
  p_w_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(w_ld) |-> $stable(w_q));

endmodule

// File: rtl/conv1d_outstage.sv
module conv1d_outstage #(
  parameter int W     = 16,
  parameter int FRAC  = 9,
  parameter int ACC_W = 26
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [ACC_W-1:0] acc_in,
  input  logic                    vld_in,
  output logic                    res_valid,
  output logic [W-FRAC-1:0]       res_int,
  output logic [FRAC-1:0]         res_frac
);

  localparam logic signed [ACC_W-1:0] SAT_MAX = ACC_W'({1'b0, {(W - 1){1'b1}}});
  localparam logic signed [ACC_W-1:0] SAT_MIN = -SAT_MAX - 1;

  logic [W-1:0] word_q, word_d;
  logic         vld_q;

  always_comb begin
    if (acc_in > SAT_MAX)      word_d = {1'b0, {(W - 1){1'b1}}};
    else if (acc_in < SAT_MIN) word_d = {1'b1, {(W - 1){1'b0}}};
    else                       word_d = acc_in[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= vld_in;
      if (vld_in) word_q <= word_d;
    end
  end

  assign res_valid = vld_q;
  assign res_int   = word_q[W-1:FRAC];
  assign res_frac  = word_q[FRAC-1:0];

  // R5: a positive overflow lands on the largest code, a negative one on the smallest
  p_sat_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_in && acc_in > SAT_MAX) |=> ({res_int, res_frac} == {1'b0, {(W - 1){1'b1}}}));
  p_sat_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_in && acc_in < SAT_MIN) |=> ({res_int, res_frac} == {1'b1, {(W - 1){1'b0}}}));

endmodule

// File: rtl/conv1d_sys_array.sv
module conv1d_sys_array #(
  parameter int K    = 4,
  parameter int W    = 16,
  parameter int FRAC = 9,
  parameter int AW   = 8,
  localparam int KAW = (K > 1) ? $clog2(K) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  output logic              wt_rd,
  output logic [KAW-1:0]    wt_addr,
  input  logic [W-1:0]      wt_data,
  output logic              smp_rd,
  output logic [AW-1:0]     smp_addr,
  input  logic [W-1:0]      smp_data,
  output logic              res_valid,
  output logic [W-FRAC-1:0] res_int,
  output logic [FRAC-1:0]   res_frac
);

  localparam int ACC_W = 2 * W - FRAC + $clog2(K) + 1;

  logic [1:0] rst_pipe_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s = rst_pipe_q[1];

  logic           ld_en_q;
  logic [KAW-1:0] ld_idx_q;
  logic           tag_q;

  conv1d_ctrl #(.K(K), .AW(AW), .KAW(KAW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_s),
    .en       (en),
    .wt_rd    (wt_rd),
    .wt_addr  (wt_addr),
    .smp_rd   (smp_rd),
    .smp_addr (smp_addr),
    .ld_en_q  (ld_en_q),
    .ld_idx_q (ld_idx_q),
    .tag_q    (tag_q)
  );

  logic signed [W-1:0]     x_chain  [K+1];
  logic signed [ACC_W-1:0] ps_chain [K+1];

  assign x_chain[0]  = $signed(smp_data);
  assign ps_chain[0] = '0;

  for (genvar g = 0; g < K; g++) begin : g_pe
    conv1d_pe #(.W(W), .FRAC(FRAC), .ACC_W(ACC_W)) u_pe (
      .clk      (clk),
      .rst_n    (rst_s),
      .w_ld     (ld_en_q && (ld_idx_q == KAW'(g))),
      .w_data   ($signed(wt_data)),
      .x_in     (x_chain[g]),
      .psum_in  (ps_chain[g]),
      .x_out    (x_chain[g+1]),
      .psum_out (ps_chain[g+1])
    );
  end

  logic [K-1:0] vld_q, vld_d;

  always_comb vld_d = (vld_q << 1) | K'(tag_q);

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  conv1d_outstage #(.W(W), .FRAC(FRAC), .ACC_W(ACC_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_s),
    .acc_in    (ps_chain[K]),
    .vld_in    (vld_q[K-1]),
    .res_valid (res_valid),
    .res_int   (res_int),
    .res_frac  (res_frac)
  );

  // R7: the cycle after the first sample fetch of a run carries no result
  p_fill_quiet_r7: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(smp_rd) |=> !res_valid);

  // R9: while reset is held, no strobe or result is raised
  p_reset_quiet_r9: assert property (@(posedge clk)
    !rst_s |-> (!res_valid && !wt_rd && !smp_rd));

endmodule

// File: tb/conv1d_sys_array_bench.sv
module conv1d_sys_array_bench;

  localparam int CLK_PERIOD = 10;
  localparam int K    = 4;
  localparam int W    = 16;
  localparam int FRAC = 9;
  localparam int AW   = 8;
  localparam int KAW  = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              en = 1'b0;
  logic              wt_rd, smp_rd, res_valid;
  logic [KAW-1:0]    wt_addr;
  logic [AW-1:0]     smp_addr;
  logic [W-1:0]      wt_data = '0;
  logic [W-1:0]      smp_data = '0;
  logic [W-FRAC-1:0] res_int;
  logic [FRAC-1:0]   res_frac;

  conv1d_sys_array #(.K(K), .W(W), .FRAC(FRAC), .AW(AW)) u_conv1d_sys_array (
    .clk(clk), .rst_n(rst_n), .en(en),
    .wt_rd(wt_rd), .wt_addr(wt_addr), .wt_data(wt_data),
    .smp_rd(smp_rd), .smp_addr(smp_addr), .smp_data(smp_data),
    .res_valid(res_valid), .res_int(res_int), .res_frac(res_frac)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [W-1:0] wmem [0:(1<<KAW)-1];
  logic [W-1:0] smem [0:(1<<AW)-1];

  always @(posedge clk) begin
    wt_data  <= wmem[wt_addr];
    smp_data <= smem[smp_addr];
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_word [0:255];
  int exp_cyc  [0:255];
  int exp_total = 0;
  int got = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, expv, $time);
    end
  endtask

  function automatic int ref_y(input int n);
    longint acc = 0;
    for (int i = 0; i < K; i++) begin
      longint p = longint'($signed(wmem[i])) * longint'($signed(smem[n - i]));
      acc += (p + 256) >>> 9;
    end
    if (acc > 32767)  acc = 32767;
    if (acc < -32768) acc = -32768;
    return int'(acc) & 16'hFFFF;
  endfunction

  // result monitor: R1 field split, R4 value, R5 clamp, R6 order and timing
  always @(negedge clk) begin
    if (mon_on && rst_n && res_valid) begin
      if (got >= exp_total) begin
        chk(1'b0, "R7 unexpected result", got, exp_total);
      end else begin
        chk({res_int, res_frac} == exp_word[got][15:0], "R1/R4/R5 result word",
            int'({res_int, res_frac}), exp_word[got]);
        chk(res_int == exp_word[got][15:9], "R1 integer field",
            int'(res_int), exp_word[got][15:9]);
        chk(cyc == exp_cyc[got], "R6 result cycle", cyc, exp_cyc[got]);
      end
      got++;
    end
  end

  task automatic run(input int nsmp, input bit poke_drain);
    int wcnt = 0;
    int scnt = 0;
    exp_total = (nsmp >= K) ? nsmp - K + 1 : 0;
    for (int n = K - 1; n < nsmp; n++) exp_word[n-K+1] = ref_y(n);
    got = 0;
    @(negedge clk);
    en = 1'b1;
    forever begin
      @(negedge clk);
      if (scnt == nsmp) begin
        en = 1'b0;
        #1;
        chk(!smp_rd, "R3 fetch stops with en", int'(smp_rd), 0);
        break;
      end
      if (wt_rd) begin
        chk(int'(wt_addr) == wcnt, "R2 coefficient address", int'(wt_addr), wcnt);
        wcnt++;
      end
      if (smp_rd) begin
        chk(int'(smp_addr) == scnt, "R3 sample address", int'(smp_addr), scnt);
        chk(wcnt == K, "R2 load complete before samples", wcnt, K);
        if (scnt >= K - 1) exp_cyc[scnt-K+1] = cyc + K + 2;
        scnt++;
      end
    end
    if (poke_drain) begin
      @(negedge clk);
      en = 1'b1;
      for (int j = 0; j < 2; j++) begin
        @(negedge clk);
        chk(!wt_rd && !smp_rd, "R8 en ignored while draining", int'({wt_rd, smp_rd}), 0);
      end
      en = 1'b0;
    end
    repeat (K + 10) @(negedge clk);
    chk(got == exp_total, "R6 result count", got, exp_total);
  endtask

  task automatic fill_w(input int a, input int b, input int c, input int d);
    wmem[0] = W'(a); wmem[1] = W'(b); wmem[2] = W'(c); wmem[3] = W'(d);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    for (int i = 0; i < (1 << AW); i++) smem[i] = '0;
    fill_w(0, 0, 0, 0);
    #(CLK_PERIOD * 3 + 2);
    // R9 reset state
    chk(!res_valid && !wt_rd && !smp_rd, "R9 reset strobes", int'({res_valid, wt_rd, smp_rd}), 0);
    chk({res_int, res_frac} == '0, "R9 reset result", int'({res_int, res_frac}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    // R1/R4 directed: single tap of 1.0, so output is the delayed sample
    fill_w(512, 0, 0, 0);
    for (int i = 0; i < 12; i++) smem[i] = W'(i * 300 - 1500);
    run(12, 1'b0);

    // R4 rounding ties: 1 LSB weight times +/-256 (exact half)
    fill_w(1, 1, 0, 0);
    for (int i = 0; i < 10; i++) smem[i] = (i % 2 == 0) ? W'(256) : W'(-256);
    smem[7] = W'(257);
    run(10, 1'b0);

    // R5 positive clamp
    fill_w(16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF);
    for (int i = 0; i < 8; i++) smem[i] = 16'h7FFF;
    run(8, 1'b0);

    // R5 negative clamp, with R8 drain poke
    for (int i = 0; i < 8; i++) smem[i] = 16'h8000;
    run(8, 1'b1);

    // R7 run shorter than the kernel gives no result
    fill_w(512, 512, 512, 512);
    for (int i = 0; i < 3; i++) smem[i] = W'(1000);
    run(3, 1'b0);

    // constrained random runs
    for (int r = 0; r < 6; r++) begin
      int sh = (r % 3) * 3;
      for (int i = 0; i < K; i++) wmem[i] = W'($signed(W'($urandom)) >>> sh);
      for (int i = 0; i < 60; i++) smem[i] = W'($signed(W'($urandom)) >>> (sh + 1));
      run(20 + r * 6, (r % 2) == 1);
    end

    // R9 asynchronous reset in the middle of streaming
    mon_on = 1'b0;
    @(negedge clk);
    en = 1'b1;
    repeat (K + 8) @(negedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    chk(!res_valid && !wt_rd && !smp_rd, "R9 async clear", int'({res_valid, wt_rd, smp_rd}), 0);
    chk({res_int, res_frac} == '0, "R9 async clear result", int'({res_int, res_frac}), 0);
    en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!res_valid && !wt_rd && !smp_rd, "R9 idle after release", int'({res_valid, wt_rd, smp_rd}), 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule